// File: doc/BRIEF.md
# Low-Power Compare Timer

A 16-bit up-counter with a small register interface. The counter advances on a step produced from one of four input tick sources. That source may be divided by a selectable power of two, or the divider can be bypassed. When the count equals a programmed compare value on a step, a sticky match flag is set. Depending on a mode bit, the counter then either restarts from zero or keeps running freely until it wraps past its maximum. Software clears the flag by writing a one to it. The block drives a level interrupt while the flag and the interrupt enable are both set.

Each input tick is a one-cycle enable in the system clock domain. It stands in for the edge of a slow clock that has already been brought into that domain. Software configures the divider and the compare value with the timer stopped, then sets the enable bit as the final step. Clearing the enable bit stops the timer and returns all counting state to zero.

Top module: `lpct_timer`

## Requirements
- R1: After reset all four registers read zero and `irq_o` is low. Address 0 is control, 1 is prescaler, 2 is compare, 3 is the read-only counter.
- R2: The prescaler register holds the source select in bits 1:0, the bypass in bit 2 and the divide code n in bits 6:3. With bypass at 1 the counter advances once per selected tick. With bypass at 0 it advances once per 2^(n+1) selected ticks.
- R3: Ticks on sources other than the one the select field names have no effect on the counter.
- R4: The control register holds enable in bit 0, free-run in bit 1, interrupt enable in bit 2 and the match flag in bit 3. On a step with count equal to compare, the flag sets. With free-run at 0 the counter returns to zero on that step.
- R5: With free-run at 1, a match sets the flag but the count keeps incrementing. The counter wraps from 0xFFFF to 0 and is reset only by that overflow.
- R6: Writing control with bit 3 at 1 clears the match flag. Writing bit 3 at 0 leaves the flag unchanged.
- R7: When a flag clear and a new match fall in the same cycle, the flag stays set.
- R8: One cycle after the enable bit reads 0, the counter, the prescaler phase and the match flag are all zero.
- R9: `irq_o` is high exactly while interrupt enable and the match flag are both 1.
- R10: Writes to the prescaler register while enabled leave it unchanged.
- R11: A write to the compare register takes effect only while disabled or while the match flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 4 | One-cycle tick enables of the four count sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address for read and write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A new compare match and a software clear of the flag can land in the same cycle. So can a compare write and the match that unlocks it. The bench provokes the first case directly: it counts ticks so that a write-one-to-clear sits on exactly the step where the count reaches the compare value, and the flag is then expected to read back set. The random phase mixes writes of every register with tick patterns on all sources. A cycle model, built from the requirements, judges every readback and the interrupt level on each cycle.

// File: rtl/lpct_pkg.sv
package lpct_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_PSC  = 2'd1,
      REG_CMP  = 2'd2,
      REG_CNT  = 2'd3
   } lpct_reg_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_FREE_BIT = 1;
   localparam int CTRL_IE_BIT   = 2;
   localparam int CTRL_FLAG_BIT = 3;
   localparam int CTRL_BITS     = 4;

endpackage

// File: rtl/lpct_prescale.sv
module lpct_prescale #(
   parameter int SRC_N      = 4,
   parameter int DIV_W      = 4,
   parameter bit HAS_BYPASS = 1'b1,
   localparam int SEL_W     = (SRC_N > 1) ? $clog2(SRC_N) : 1,
   localparam int PHASE_W   = 2 ** DIV_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic [SRC_N-1:0]   src_tick_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               byp_i,
   input  logic [DIV_W-1:0]   div_i,
   output logic               step_o
);

   if (SRC_N != 2 ** SEL_W) begin : g_bad_src
      $error("lpct_prescale: SRC_N must be a power of two");
   end
   if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div
      $error("lpct_prescale: DIV_W must lie in 1..5");
   end

   logic               tick;
   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] wrap_mask;
   logic               phase_full;

   assign tick = src_tick_i[sel_i];

   for (genvar g = 0; g < PHASE_W; g++) begin : g_mask
      assign wrap_mask[g] = (32'(div_i) >= g);
   end

   assign phase_full = &(phase_q | ~wrap_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run_i) begin
         phase_q <= '0;
      end else if (tick) begin
         phase_q <= phase_q + PHASE_W'(1);
      end
   end

   if (HAS_BYPASS) begin : g_bypass
      assign step_o = run_i & tick & (byp_i | phase_full);
   end else begin : g_divide_only
      assign step_o = run_i & tick & phase_full;
   end

   assert_phase_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (phase_q == '0));

   assert_step_from_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> src_tick_i[sel_i]);

   assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick) |=> $stable(phase_q));

endmodule

// File: rtl/lpct_core.sv
module lpct_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             free_i,
   input  logic             step_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o
);

   if (CNT_W < 2) begin : g_bad_w
      $error("lpct_core: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic             hit;

   assign hit = step_i && (cnt_q == cmp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         if (hit && !free_i) cnt_q <= '0;
         else                cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (!run_i) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   assert_disable_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0 && !flag_q));

   assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !step_i) |=> $stable(cnt_q));

   assert_match_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && step_i && !free_i && cnt_q == cmp_i) |=> (cnt_q == '0 && flag_q));

   assert_free_continue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && step_i && free_i && cnt_q == cmp_i) |=>
         (cnt_q == $past(cnt_q) + CNT_W'(1) && flag_q));

   assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && clr_i && !(step_i && cnt_q == cmp_i)) |=> !flag_q);

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && flag_q && !clr_i) |=> flag_q);

   assert_match_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && clr_i && step_i && cnt_q == cmp_i) |=> flag_q);

endmodule

// File: rtl/lpct_timer.sv
module lpct_timer #(
   parameter int CNT_W      = 16,
   parameter int DIV_W      = 4,
   parameter int SRC_N      = 4,
   parameter bit HAS_BYPASS = 1'b1,
   localparam int SEL_W     = (SRC_N > 1) ? $clog2(SRC_N) : 1,
   localparam int PSC_W     = SEL_W + 1 + DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src_tick_i,
   input  logic             bus_wr_i,
   input  logic [1:0]       bus_addr_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] bus_rdata_o,
   output logic             irq_o
);
   import lpct_pkg::*;

   if (CNT_W < PSC_W || CNT_W < CTRL_BITS) begin : g_bad_width
      $error("lpct_timer: CNT_W too narrow for the register fields");
   end

   logic             en_q, free_q, ie_q, byp_q;
   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt;
   logic             flag;
   logic             step;
   logic             wr_ctrl, wr_psc, wr_cmp, clr_req;

   assign wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
   assign wr_psc  = bus_wr_i && (bus_addr_i == REG_PSC);
   assign wr_cmp  = bus_wr_i && (bus_addr_i == REG_CMP);
   assign clr_req = wr_ctrl && bus_wdata_i[CTRL_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         free_q <= 1'b0;
         ie_q   <= 1'b0;
      end else if (wr_ctrl) begin
         en_q   <= bus_wdata_i[CTRL_EN_BIT];
         free_q <= bus_wdata_i[CTRL_FREE_BIT];
         ie_q   <= bus_wdata_i[CTRL_IE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         byp_q <= 1'b0;
         div_q <= '0;
      end else if (wr_psc && !en_q) begin
         sel_q <= bus_wdata_i[SEL_W-1:0];
         byp_q <= bus_wdata_i[SEL_W];
         div_q <= bus_wdata_i[SEL_W+1 +: DIV_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (wr_cmp && (!en_q || flag)) begin
         cmp_q <= bus_wdata_i;
      end
   end

   lpct_prescale #(
      .SRC_N      (SRC_N),
      .DIV_W      (DIV_W),
      .HAS_BYPASS (HAS_BYPASS)
   ) u_prescale (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (en_q),
      .src_tick_i (src_tick_i),
      .sel_i      (sel_q),
      .byp_i      (byp_q),
      .div_i      (div_q),
      .step_o     (step)
   );

   lpct_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (en_q),
      .free_i (free_q),
      .step_i (step),
      .clr_i  (clr_req),
      .cmp_i  (cmp_q),
      .cnt_o  (cnt),
      .flag_o (flag)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (lpct_reg_e'(bus_addr_i))
         REG_CTRL: begin
            bus_rdata_o[CTRL_EN_BIT]   = en_q;
            bus_rdata_o[CTRL_FREE_BIT] = free_q;
            bus_rdata_o[CTRL_IE_BIT]   = ie_q;
            bus_rdata_o[CTRL_FLAG_BIT] = flag;
         end
         REG_PSC:  bus_rdata_o[PSC_W-1:0] = {div_q, byp_q, sel_q};
         REG_CMP:  bus_rdata_o = cmp_q;
         REG_CNT:  bus_rdata_o = cnt;
         default:  bus_rdata_o = '0;
      endcase
   end

   assign irq_o = ie_q & flag;

   assert_psc_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == REG_PSC && en_q) |=> $stable({sel_q, byp_q, div_q}));

   assert_cmp_guarded_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == REG_CMP && en_q && !flag) |=> $stable(cmp_q));

   assert_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !irq_o);

endmodule

// File: tb/lpct_timer_tb_top.sv
module lpct_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src = '0;
   logic        wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int    n_run = 0;
   int    n_fail = 0;
   string cur = "R1";

   always #10 clk = ~clk;

   lpct_timer dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_tick_i  (src),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   // reference model written from the requirements
   bit        m_en, m_free, m_ie, m_flag, m_byp;
   bit [1:0]  m_sel;
   bit [3:0]  m_div;
   bit [15:0] m_cmp, m_cnt, m_pc;

   always @(posedge clk) begin
      bit tk, st, mt, clr, old_en, old_flag;
      bit [15:0] mk;
      if (!rst_n) begin
         m_en = 0; m_free = 0; m_ie = 0; m_flag = 0; m_byp = 0;
         m_sel = 0; m_div = 0; m_cmp = 0; m_cnt = 0; m_pc = 0;
      end else begin
         tk       = src[m_sel];
         mk       = 16'((32'h2 << m_div) - 1);
         st       = m_en && tk && (m_byp || ((m_pc & mk) == mk));
         mt       = st && (m_cnt == m_cmp);
         clr      = wr && addr == 2'd0 && wdata[3];
         old_en   = m_en;
         old_flag = m_flag;
         if (!m_en) begin
            m_cnt = 0; m_pc = 0; m_flag = 0;
         end else begin
            if (tk) m_pc = m_pc + 16'd1;
            if (st) m_cnt = (mt && !m_free) ? 16'd0 : m_cnt + 16'd1;
            if (mt) m_flag = 1;
            else if (clr) m_flag = 0;
         end
         if (wr) begin
            case (addr)
               2'd0: {m_ie, m_free, m_en} = wdata[2:0];
               2'd1: if (!old_en) {m_div, m_byp, m_sel} = wdata[6:0];
               2'd2: if (!old_en || old_flag) m_cmp = wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [15:0] mread(input logic [1:0] a);
      case (a)
         2'd0:    return {12'd0, m_flag, m_ie, m_free, m_en};
         2'd1:    return {9'd0, m_div, m_byp, m_sel};
         2'd2:    return m_cmp;
         default: return m_cnt;
      endcase
   endfunction

   task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
      end
   endtask

   task automatic cyc(input bit w, input logic [1:0] a, input logic [15:0] d, input logic [3:0] t);
      @(negedge clk);
      wr = w; addr = a; wdata = d; src = t;
      #1;
      check("irq (R9)", {15'd0, irq}, {15'd0, m_ie & m_flag});
      check("readback", rdata, mread(a));
   endtask

   task automatic peek(input logic [1:0] a, input logic [15:0] exp, input string what);
      cyc(0, a, 16'd0, 4'd0);
      check(what, rdata, exp);
   endtask

   task automatic ticks(input int n, input logic [3:0] t);
      for (int i = 0; i < n; i++) cyc(0, 2'd3, 16'd0, t);
   endtask

   task automatic put(input logic [1:0] a, input logic [15:0] d);
      cyc(1, a, d, 4'd0);
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      cur = "R1";
      peek(2'd0, 16'h0000, "ctrl after reset");
      peek(2'd1, 16'h0000, "psc after reset");
      peek(2'd2, 16'h0000, "cmp after reset");
      peek(2'd3, 16'h0000, "cnt after reset");
      check("irq after reset", {15'd0, irq}, 16'd0);

      cur = "R2";
      put(2'd1, 16'h0004);
      put(2'd2, 16'hFFFF);
      put(2'd0, 16'h0001);
      ticks(7, 4'b0001);
      peek(2'd3, 16'd7, "bypass count");

      cur = "R8";
      put(2'd0, 16'h0000);
      cyc(0, 2'd3, 16'd0, 4'd0);
      peek(2'd3, 16'd0, "counter cleared on disable");

      cur = "R2";
      put(2'd1, 16'h0011);
      put(2'd0, 16'h0001);
      ticks(24, 4'b0010);
      peek(2'd3, 16'd3, "divide by 8");

      cur = "R3";
      ticks(10, 4'b1101);
      peek(2'd3, 16'd3, "other sources ignored");

      cur = "R8";
      put(2'd0, 16'h0000);
      cyc(0, 2'd3, 16'd0, 4'd0);
      put(2'd0, 16'h0001);
      ticks(5, 4'b0010);
      put(2'd0, 16'h0000);
      cyc(0, 2'd3, 16'd0, 4'd0);
      put(2'd0, 16'h0001);
      ticks(3, 4'b0010);
      peek(2'd3, 16'd0, "prescaler phase cleared");
      ticks(5, 4'b0010);
      peek(2'd3, 16'd1, "fresh phase completes");

      cur = "R4";
      put(2'd0, 16'h0000);
      cyc(0, 2'd3, 16'd0, 4'd0);
      put(2'd1, 16'h0004);
      put(2'd2, 16'd3);
      put(2'd0, 16'h0005);
      ticks(4, 4'b0001);
      peek(2'd3, 16'd0, "restart on match");
      peek(2'd0, 16'h000D, "flag set on match");
      cur = "R9";
      check("irq with flag and enable", {15'd0, irq}, 16'd1);

      cur = "R6";
      put(2'd0, 16'h0005);
      peek(2'd0, 16'h000D, "write zero keeps flag");
      put(2'd0, 16'h000D);
      peek(2'd0, 16'h0005, "write one clears flag");
      check("irq after clear", {15'd0, irq}, 16'd0);

      cur = "R11";
      put(2'd2, 16'd9);
      peek(2'd2, 16'd3, "compare locked");
      ticks(4, 4'b0001);
      put(2'd2, 16'd9);
      peek(2'd2, 16'd9, "compare open with flag");

      cur = "R10";
      put(2'd1, 16'h007F);
      peek(2'd1, 16'h0004, "prescaler locked");

      cur = "R7";
      put(2'd0, 16'h0000);
      cyc(0, 2'd3, 16'd0, 4'd0);
      put(2'd2, 16'd2);
      put(2'd0, 16'h0005);
      ticks(5, 4'b0001);
      cyc(1, 2'd0, 16'h000D, 4'b0001);
      peek(2'd0, 16'h000D, "match wins over clear");
      peek(2'd3, 16'd0, "count restarted");

      cur = "R5";
      put(2'd0, 16'h0000);
      cyc(0, 2'd3, 16'd0, 4'd0);
      put(2'd1, 16'h0006);
      put(2'd2, 16'd5);
      put(2'd0, 16'h0003);
      ticks(6, 4'b0100);
      peek(2'd3, 16'd6, "free run passes compare");
      peek(2'd0, 16'h000B, "flag in free run");
      ticks(65532, 4'b0100);
      peek(2'd3, 16'd2, "wrap past maximum");

      cur = "RND-R2-R11";
      put(2'd0, 16'h0000);
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         logic [1:0]  a;
         logic [15:0] d;
         r = $urandom % 100;
         a = 2'($urandom % 4);
         d = 16'($urandom);
         if (r < 6) begin
            case (a)
               2'd0: d[0] = ($urandom % 5) != 0;
               2'd1: d[6:3] = 4'($urandom % 3);
               2'd2: d = 16'($urandom % 8);
               default: ;
            endcase
            cyc(1, a, d, 4'($urandom));
         end else begin
            cyc(0, a, 16'd0, 4'($urandom));
         end
      end

      finish_run();
   end

endmodule